// File: doc/BRIEF.md
# Quad Wiper Register Front End with Serial Control

This block is the digital side of a four-channel digital potentiometer. A host talks to it through a four-wire serial peripheral interface (serial clock, active-low select, data in, data out). The block holds four 8-bit wiper codes, one for each channel, and a retained store that keeps one code per channel across resets. The wiper codes leave the block on a flat output bus. A resistor ladder outside the block decodes them.

Every transfer is a two-byte frame: a command byte, then a data byte. The command selects one of four operations and one of four channels. The operations are: read a wiper, write a wiper, write a wiper and store it, and write the control register. After each reset, the block copies the retained code of each channel into its wiper register. It then ignores the serial port until the select line makes its first high-to-low transition. A store starts an internal write that lasts a fixed number of clock cycles. This write runs to completion even after the select line goes high. Any write that arrives while it runs is dropped. A control-register bit sets the data-out pin to push-pull or to open-drain drive.

Top module: `qw_spi_wiper`

## Requirements
- R1: `wiper_code` presents channel k's 8-bit wiper register unaltered in bits [8k+7:8k], for k = 0..3. Code 0 is the end nearest the low terminal and code 255 the end nearest the high terminal.
- R2: `sdi` is taken on rising `sck` edges only while `cs_n` is low, most significant bit first. The command byte has the opcode in bits [7:6] and the channel in bits [5:4]. The opcodes are 00 read wiper, 01 write wiper, 10 write wiper and store, and 11 write control register. The data byte follows.
- R3: In a read frame, the addressed wiper code appears on the data-out line during the data byte, MSB first. Each bit changes after a falling `sck` edge, so it is stable at the next rising edge.
- R4: While `cs_n` is high, `sdo_en` is low (pin released), and `standby` is high unless `busy` is high.
- R5: After reset, no frame has any effect until `cs_n` has gone from high to low.
- R6: Control-register bit 1 selects the data-out drive, and it resets to 0. When it is 0 (push-pull), `sdo_en` is high for every data bit and `sdo_out` carries the bit. When it is 1 (open-drain), `sdo_out` is 0 and `sdo_en` is high only for 0 bits.
- R7: After reset, each wiper register takes the value held in its channel's retained store.
- R8: A frame with fewer than 16 bits when `cs_n` rises changes no register.
- R9: A store command writes both the wiper and its retained value. It raises `busy` for exactly BUSY_CYCLES clock cycles, even if `cs_n` rises first.
- R10: A write, store or control write that completes while `busy` is high is ignored. The same write is accepted once `busy` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| sck | input | 1 | Serial clock from the host |
| cs_n | input | 1 | Select, active low |
| sdi | input | 1 | Serial data from the host |
| sdo_out | output | 1 | Data-out level to drive |
| sdo_en | output | 1 | Data-out enable; low means the pin is released |
| wiper_code | output | 32 | Four 8-bit wiper codes, channel 0 in the low byte |
| busy | output | 1 | Internal retained-store write in progress |
| standby | output | 1 | Deselected and idle |

## Verification
The bench first holds the select line low through reset and clocks a complete write frame. A design that arms on the level instead of on a falling edge would apply that write. Next comes a frame cut off after twelve bits. A design that commits a partial frame would change a wiper there. Read frames run in both drive modes with patterns that mix 0 and 1 bits. Wrong bit order, a wrong shift edge, or a mode bit that does not gate the enable would corrupt the value that a pulled-up line returns. A write lands in the middle of a store. The bench then resets and checks which value the reload brings back. A design that ends busy early, lets a write through during busy, or fails to retain the stored code shows up as a wrong wiper value.

// File: rtl/qw_pkg.sv
package qw_pkg;
  localparam int DATA_W     = 8;
  localparam int CH_W       = 2;
  localparam int NUM_CH     = 1 << CH_W;
  localparam int FRAME_BITS = 2 * DATA_W;
  localparam int CNT_W      = $clog2(FRAME_BITS + 1);
  localparam int OP_MSB     = DATA_W - 1;
  localparam int CH_MSB     = DATA_W - 3;

  typedef enum logic [1:0] {
    OP_READ     = 2'b00,
    OP_WRITE    = 2'b01,
    OP_STORE    = 2'b10,
    OP_CTRL     = 2'b11
  } op_e;
endpackage

// File: rtl/qw_sync.sv
module qw_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain <= {STAGES{RST_VAL}};
    else     chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/qw_frame_rx.sv
module qw_frame_rx
  import qw_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  sck_s,
  input  logic                  cs_s,
  input  logic                  sdi_s,
  output logic                  armed,
  output logic                  sck_fall,
  output logic [CNT_W-1:0]      bit_cnt,
  output logic                  frame_done,
  output logic [FRAME_BITS-1:0] frame_bits
);
  logic sck_q, cs_q;
  logic sck_rise, cs_fall;

  assign sck_rise = sck_s & ~sck_q;
  assign sck_fall = ~sck_s & sck_q;
  assign cs_fall  = ~cs_s & cs_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sck_q      <= 1'b0;
      cs_q       <= 1'b0;
      armed      <= 1'b0;
      bit_cnt    <= '0;
      frame_done <= 1'b0;
      frame_bits <= '0;
    end else begin
      sck_q      <= sck_s;
      cs_q       <= cs_s;
      frame_done <= 1'b0;
      if (cs_fall) begin
        armed   <= 1'b1;
        bit_cnt <= '0;
      end else if (!cs_s && armed && sck_rise &&
                   bit_cnt < CNT_W'(FRAME_BITS)) begin
        frame_bits <= {frame_bits[FRAME_BITS-2:0], sdi_s};
        bit_cnt    <= bit_cnt + 1'b1;
        if (bit_cnt == CNT_W'(FRAME_BITS - 1)) frame_done <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/qw_nv_bank.sv
module qw_nv_bank
  import qw_pkg::*;
#(
  parameter int                         BUSY_CYCLES = 200,
  parameter logic [NUM_CH*DATA_W-1:0]   NV_INIT     = '0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [CH_W-1:0]   waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [CH_W-1:0]   raddr,
  output logic [DATA_W-1:0] rdata,
  output logic              busy
);
  localparam int BW = $clog2(BUSY_CYCLES + 1);

  logic [DATA_W-1:0] mem [NUM_CH];
  logic [BW-1:0]     busy_cnt;

  initial begin
    for (int i = 0; i < NUM_CH; i++) mem[i] = NV_INIT[i*DATA_W +: DATA_W];
  end

  always_ff @(posedge clk) begin
    if (we && !busy) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end

  always_ff @(posedge clk) begin
    if (rst)                busy_cnt <= '0;
    else if (we && !busy)   busy_cnt <= BW'(BUSY_CYCLES);
    else if (busy_cnt != 0) busy_cnt <= busy_cnt - 1'b1;
  end

  assign busy = (busy_cnt != '0);
endmodule

// File: rtl/qw_spi_wiper.sv
module qw_spi_wiper
  import qw_pkg::*;
#(
  parameter int                       BUSY_CYCLES = 200,
  parameter int                       SYNC_STAGES = 2,
  parameter logic [NUM_CH*DATA_W-1:0] NV_INIT     = 32'h80808080
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     sck,
  input  logic                     cs_n,
  input  logic                     sdi,
  output logic                     sdo_out,
  output logic                     sdo_en,
  output logic [NUM_CH*DATA_W-1:0] wiper_code,
  output logic                     busy,
  output logic                     standby
);
  localparam logic [CH_W:0] LD_LAST = (CH_W + 1)'(NUM_CH);

  logic sck_s, cs_s, sdi_s;
  logic armed, sck_fall, frame_done;
  logic [CNT_W-1:0]      bit_cnt;
  logic [FRAME_BITS-1:0] frame_bits;

  qw_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_sck
    (.clk(clk), .rst(rst), .d(sck),  .q(sck_s));
  qw_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_cs
    (.clk(clk), .rst(rst), .d(cs_n), .q(cs_s));
  qw_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_sdi
    (.clk(clk), .rst(rst), .d(sdi),  .q(sdi_s));

  qw_frame_rx u_rx (
    .clk(clk), .rst(rst), .sck_s(sck_s), .cs_s(cs_s), .sdi_s(sdi_s),
    .armed(armed), .sck_fall(sck_fall), .bit_cnt(bit_cnt),
    .frame_done(frame_done), .frame_bits(frame_bits)
  );

  // Completed frame fields
  op_e               f_op;
  logic [CH_W-1:0]   f_ch;
  logic [DATA_W-1:0] f_data;
  assign f_op   = op_e'(frame_bits[FRAME_BITS-1 -: 2]);
  assign f_ch   = frame_bits[DATA_W + CH_MSB -: CH_W];
  assign f_data = frame_bits[DATA_W-1:0];

  // Command byte while the data byte is still arriving
  op_e             c_op;
  logic [CH_W-1:0] c_ch;
  assign c_op = op_e'(frame_bits[OP_MSB -: 2]);
  assign c_ch = frame_bits[CH_MSB -: CH_W];

  // Power-up reload and register state
  logic [CH_W:0]     ld_cnt;
  logic              loaded;
  logic [CH_W-1:0]   ld_prev;
  logic [DATA_W-1:0] nv_rdata;
  logic [DATA_W-1:0] wiper_q [NUM_CH];
  logic              od_mode_q;
  logic              exec_ok, store_we;

  assign ld_prev  = CH_W'(ld_cnt - 1'b1);
  assign exec_ok  = loaded && frame_done && !busy;
  assign store_we = exec_ok && (f_op == OP_STORE);

  qw_nv_bank #(.BUSY_CYCLES(BUSY_CYCLES), .NV_INIT(NV_INIT)) u_nv (
    .clk(clk), .rst(rst), .we(store_we), .waddr(f_ch), .wdata(f_data),
    .raddr(ld_cnt[CH_W-1:0]), .rdata(nv_rdata), .busy(busy)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ld_cnt    <= '0;
      loaded    <= 1'b0;
      od_mode_q <= 1'b0;
      for (int i = 0; i < NUM_CH; i++) wiper_q[i] <= '0;
    end else if (!loaded) begin
      ld_cnt <= ld_cnt + 1'b1;
      if (ld_cnt != '0) wiper_q[ld_prev] <= nv_rdata;
      if (ld_cnt == LD_LAST) loaded <= 1'b1;
    end else if (exec_ok) begin
      case (f_op)
        OP_WRITE, OP_STORE: wiper_q[f_ch] <= f_data;
        OP_CTRL:            od_mode_q     <= f_data[1];
        default: ;
      endcase
    end
  end

  for (genvar k = 0; k < NUM_CH; k++) begin : g_bus
    assign wiper_code[k*DATA_W +: DATA_W] = wiper_q[k];
  end

  // Read shifter: loads on the fall after the command byte
  logic [DATA_W-1:0] tx_q;
  logic              rd_active;

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_q      <= '0;
      rd_active <= 1'b0;
    end else if (cs_s || bit_cnt == CNT_W'(FRAME_BITS)) begin
      rd_active <= 1'b0;
    end else if (sck_fall && armed && loaded) begin
      if (bit_cnt == CNT_W'(DATA_W) && c_op == OP_READ) begin
        tx_q      <= wiper_q[c_ch];
        rd_active <= 1'b1;
      end else if (rd_active) begin
        tx_q <= {tx_q[DATA_W-2:0], 1'b0};
      end
    end
  end

  logic drive;
  assign drive = rd_active && !cs_s;

  always_ff @(posedge clk) begin
    if (rst) begin
      sdo_out <= 1'b0;
      sdo_en  <= 1'b0;
      standby <= 1'b0;
    end else begin
      standby <= cs_s && !busy;
      if (od_mode_q) begin
        sdo_out <= 1'b0;
        sdo_en  <= drive && !tx_q[DATA_W-1];
      end else begin
        sdo_out <= drive && tx_q[DATA_W-1];
        sdo_en  <= drive;
      end
    end
  end
endmodule

// File: rtl/qw_spi_wiper_chk.sv
module qw_spi_wiper_chk #(
  parameter int BUSY_CYCLES = 200,
  parameter int BUS_W       = 32
) (
  input logic             clk,
  input logic             rst,
  input logic             cs_s,
  input logic             sdo_en,
  input logic             sdo_out,
  input logic             od_mode,
  input logic             busy,
  input logic             standby,
  input logic             armed,
  input logic             loaded,
  input logic [BUS_W-1:0] wiper_code
);
  int busy_run;

  always_ff @(posedge clk) begin
    if (rst)       busy_run <= 0;
    else if (busy) busy_run <= busy_run + 1;
    else           busy_run <= 0;
  end

  assert_released_when_deselected_R4: assert property (@(posedge clk) disable iff (rst)
    cs_s |=> !sdo_en);

  assert_standby_not_during_busy_R4: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy)) |-> !standby);

  assert_open_drain_no_high_R6: assert property (@(posedge clk) disable iff (rst)
    (sdo_en && od_mode) |-> !sdo_out);

  assert_unarmed_no_change_R5: assert property (@(posedge clk) disable iff (rst)
    (loaded && !armed) |=> $stable(wiper_code));

  assert_busy_blocks_write_R10: assert property (@(posedge clk) disable iff (rst)
    busy |=> $stable(wiper_code));

  assert_busy_length_R9: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> (busy_run == BUSY_CYCLES));
endmodule

bind qw_spi_wiper qw_spi_wiper_chk #(.BUSY_CYCLES(BUSY_CYCLES), .BUS_W(qw_pkg::NUM_CH*qw_pkg::DATA_W)) u_chk (
  .clk(clk), .rst(rst), .cs_s(cs_s), .sdo_en(sdo_en), .sdo_out(sdo_out),
  .od_mode(od_mode_q), .busy(busy), .standby(standby), .armed(armed),
  .loaded(loaded), .wiper_code(wiper_code)
);

// File: tb/qw_spi_wiper_bench.sv
module qw_spi_wiper_bench;
  localparam int BUSY = 600;
  localparam logic [31:0] INIT = 32'h12345678;

  logic clk = 0, rst = 1, sck = 0, cs_n = 0, sdi = 0;
  logic sdo_out, sdo_en, busy, standby;
  logic [31:0] wiper_code;

  int n_tests = 0, n_fail = 0;
  logic [7:0] exp_q[$];
  logic [7:0] obs_q[$];
  bit od_expect = 0;
  int busy_clocks = 0;

  qw_spi_wiper #(.BUSY_CYCLES(BUSY), .NV_INIT(INIT)) u_qw_spi_wiper (
    .clk(clk), .rst(rst), .sck(sck), .cs_n(cs_n), .sdi(sdi),
    .sdo_out(sdo_out), .sdo_en(sdo_en), .wiper_code(wiper_code),
    .busy(busy), .standby(standby));

  always #5 clk = ~clk;
  always @(posedge clk) if (busy) busy_clocks++;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // One frame; nbits bits; optionally frames with cs_n
  task automatic frame(input logic [7:0] c, input logic [7:0] d, input int nbits, input bit use_cs);
    logic [7:0] got = '0;
    bit mode_bad = 0;
    if (use_cs) cs_n = 0;
    repeat (10) @(negedge clk);
    for (int i = 0; i < nbits; i++) begin
      sdi = (i < 8) ? c[7-i] : d[15-i];
      repeat (10) @(negedge clk);
      if (i >= 8) begin
        got[15-i] = sdo_en ? sdo_out : 1'b1;
        if (od_expect && sdo_en && sdo_out) mode_bad = 1;
        if (!od_expect && !sdo_en) mode_bad = 1;
      end
      sck = 1;
      repeat (10) @(negedge clk);
      sck = 0;
    end
    repeat (10) @(negedge clk);
    if (use_cs) cs_n = 1;
    repeat (20) @(negedge clk);
    if (c[7:6] == 2'b00 && nbits == 16) begin
      obs_q.push_back(got);
      chk(!mode_bad, "R6 drive style during read", {31'b0, mode_bad}, 32'h0);
    end
  endtask

  task automatic rd(input logic [1:0] ch, input logic [7:0] exp);
    exp_q.push_back(exp);
    frame({2'b00, ch, 4'h0}, 8'h00, 16, 1);
  endtask

  // Scoreboard monitor
  initial begin
    forever begin
      wait (obs_q.size() > 0);
      begin
        logic [7:0] o, e;
        o = obs_q.pop_front();
        e = (exp_q.size() > 0) ? exp_q.pop_front() : 8'hxx;
        chk(o === e, "R3 read data", {24'b0, o}, {24'b0, e});
      end
    end
  end

  initial begin
    #1500000;
    n_tests++; n_fail++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    // cs_n held low across reset: no falling edge yet
    repeat (5) @(negedge clk);
    rst = 0;
    repeat (20) @(negedge clk);
    chk(wiper_code === INIT, "R7 reload after reset", wiper_code, INIT);
    chk(sdo_en === 1'b0, "R4 released at reset", {31'b0, sdo_en}, 32'h0);
    frame(8'b01_00_0000, 8'h11, 16, 0);
    chk(wiper_code === INIT, "R5 no effect before first select fall", wiper_code, INIT);
    cs_n = 1;
    repeat (20) @(negedge clk);
    chk(sdo_en === 1'b0 && standby === 1'b1, "R4 deselected state", {30'b0, sdo_en, standby}, 32'h1);

    // Writes and reads, push-pull
    frame(8'b01_10_0000, 8'hA5, 16, 1);
    chk(wiper_code[23:16] === 8'hA5, "R2 write ch2", wiper_code, 32'h12A55678);
    rd(2'd2, 8'hA5);
    frame(8'b01_00_0000, 8'h00, 16, 1);
    frame(8'b01_11_0000, 8'hFF, 16, 1);
    chk(wiper_code === 32'hFFA55600, "R1 code 0 and 255 on bus", wiper_code, 32'hFFA55600);
    rd(2'd3, 8'hFF);
    rd(2'd0, 8'h00);
    rd(2'd1, 8'h56);

    // Incomplete frame
    frame(8'b01_01_0000, 8'hEE, 12, 1);
    chk(wiper_code === 32'hFFA55600, "R8 partial frame discarded", wiper_code, 32'hFFA55600);

    // Open-drain mode
    frame(8'b11_00_0000, 8'h02, 16, 1);
    od_expect = 1;
    rd(2'd2, 8'hA5);
    rd(2'd1, 8'h56);
    frame(8'b11_00_0000, 8'h00, 16, 1);
    od_expect = 0;
    rd(2'd2, 8'hA5);

    // Store, busy window, write during busy
    busy_clocks = 0;
    frame(8'b10_01_0000, 8'h3C, 16, 1);
    chk(busy === 1'b1 && standby === 1'b0, "R9 busy after store with select high", {30'b0, busy, standby}, 32'h2);
    chk(wiper_code[15:8] === 8'h3C, "R9 store writes wiper", wiper_code, 32'hFFA53C00);
    frame(8'b01_01_0000, 8'h77, 16, 1);
    chk(wiper_code[15:8] === 8'h3C, "R10 write during busy ignored", wiper_code, 32'hFFA53C00);
    wait (!busy);
    repeat (5) @(negedge clk);
    chk(busy_clocks == BUSY, "R9 busy length", busy_clocks, BUSY);
    chk(standby === 1'b1, "R4 standby after busy", {31'b0, standby}, 32'h1);
    frame(8'b01_01_0000, 8'h55, 16, 1);
    chk(wiper_code[15:8] === 8'h55, "R10 write accepted after busy", wiper_code, 32'hFFA55500);

    // Reset again: reload stored value, drive style back to push-pull
    frame(8'b11_00_0000, 8'h02, 16, 1);
    @(negedge clk); rst = 1;
    repeat (3) @(negedge clk); rst = 0;
    repeat (20) @(negedge clk);
    chk(wiper_code === 32'h12343C78, "R7 reload keeps stored code", wiper_code, 32'h12343C78);
    od_expect = 0;
    rd(2'd1, 8'h3C);
    rd(2'd0, 8'h78);

    wait (obs_q.size() == 0);
    repeat (10) @(negedge clk);
    chk(exp_q.size() == 0, "R3 all reads observed", exp_q.size(), 0);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule